// File: doc/BRIEF.md
# Inter-processor sync doorbell register

This block joins two processors that share one clock through a pair of 32-bit sync registers, one per side. Each side owns an outgoing byte. The peer sees that byte as its own incoming byte. Each side also owns an interrupt enable. Through a write-only trigger bit, either side can ring a doorbell interrupt on the other. The doorbell reaches the target only if the target has its own enable bit set.

Each side has a plain register port with an address, a write strobe, write data, byte enables and registered read data, plus one interrupt output. The register answers at one configurable address. Software uses it for small handshakes: posting a status byte, then ringing the peer to tell it that the byte has changed.

Top module: `ipc_sync_doorbell`

## Requirements
- R1: A synchronous reset clears both outgoing bytes and both enable bits. In the cycle after reset is released, both read data words are 0 and both interrupt outputs are low. A trigger written after reset to a side whose enable has been cleared raises no interrupt.
- R2: Bits 15:8 of a side's register can be read and written. They hold the byte that this side sends. The field is written only when byte enable bit 1 is set.
- R3: Bits 7:0 are read-only. They return the byte held in the peer's bits 15:8. Writes to bits 7:0 are ignored.
- R4: Bit 31 can be read and written. It is the local interrupt enable. It is written only when byte enable bit 3 is set, and it keeps its value otherwise.
- R5: A write from side 0 with bit 29 set and byte enable bit 3 set rings side 1. A write from side 1 with bit 30 set and byte enable bit 3 set rings side 0. A ring drives the target's interrupt output high for exactly one cycle, the cycle after the write. Both sides may ring each other in the same cycle.
- R6: A ring is delivered only if the target's enable bit is 1 when the write occurs. A ring that finds the target disabled is dropped. Setting the enable later does not deliver it.
- R7: Bits 30:16 always read as 0. A trigger bit that targets the writing side itself (bit 30 from side 0, bit 29 from side 1) has no effect.
- R8: The four byte lanes are independent. A lane whose byte enable is 0 is left unchanged. A trigger bit in a write whose byte enable bit 3 is 0 rings nothing.
- R9: The register answers only at address REG_ADDR. Writes at any other address change nothing and ring nothing. Reads at any other address return 0.
- R10: Read data is registered. It shows the register state and address as they were at the previous clock edge, so a write becomes visible two cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_addr | input | ADDR_W | Side 0 register address |
| s0_wr | input | 1 | Side 0 write strobe |
| s0_wdata | input | 32 | Side 0 write data |
| s0_be | input | 4 | Side 0 byte enables, bit n covers bits 8n+7:8n |
| s0_rdata | output | 32 | Side 0 registered read data |
| s0_irq | output | 1 | Side 0 doorbell interrupt pulse |
| s1_addr | input | ADDR_W | Side 1 register address |
| s1_wr | input | 1 | Side 1 write strobe |
| s1_wdata | input | 32 | Side 1 write data |
| s1_be | input | 4 | Side 1 byte enables, bit n covers bits 8n+7:8n |
| s1_rdata | output | 32 | Side 1 registered read data |
| s1_irq | output | 1 | Side 1 doorbell interrupt pulse |

## Verification
The bench drives a write on a falling edge and leaves it on the bus for one rising edge. The doorbell pulse is due one cycle later, so the interrupts are sampled on the next falling edge. The falling edge after that samples them again, where they must be low, and this confirms the one-cycle width. The read data for both sides is also sampled at that second falling edge, which is two cycles after the write was presented, because both the state and the read port are registered. Address and reset tests use the same timing: the address is changed on a falling edge and the read data is sampled one full cycle later.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;
  localparam int WORD_W   = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = WORD_W / LANE_W;
  localparam int SIDES    = 2;
  localparam int RX_LO    = 0;
  localparam int TX_LO    = 8;
  localparam int EN_BIT   = 31;
  localparam int RING_S0  = 30;
  localparam int RING_S1  = 29;
  localparam int TX_LANE  = TX_LO / LANE_W;
  localparam int EN_LANE  = EN_BIT / LANE_W;

  typedef struct packed {
    logic              en;
    logic [LANE_W-1:0] tx;
  } side_state_t;

  function automatic int ring_bit_for(input int target);
    return (target == 0) ? RING_S0 : RING_S1;
  endfunction
endpackage

// File: rtl/sync_side_regs.sv
module sync_side_regs
  import ipc_sync_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int SIDE     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output side_state_t       state,
  output logic              ring_peer
);
  localparam int PEER     = 1 - SIDE;
  localparam int OUT_BIT  = ring_bit_for(PEER);
  localparam int SELF_BIT = ring_bit_for(SIDE);

  logic wr_hit;
  logic unused_bits;

  assign wr_hit      = wr && (addr == ADDR_W'(REG_ADDR));
  assign ring_peer   = wr_hit && be[EN_LANE] && wdata[OUT_BIT];
  assign unused_bits = ^{wdata[RX_LO +: LANE_W], wdata[28:16], wdata[SELF_BIT],
                         be[0], be[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (wr_hit) begin
      if (be[TX_LANE]) state.tx <= wdata[TX_LO +: LANE_W];
      if (be[EN_LANE]) state.en <= wdata[EN_BIT];
    end
  end
endmodule

// File: rtl/sync_irq_gate.sv
module sync_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  input  logic en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ring && en;
  end
endmodule

// File: rtl/sync_read_port.sv
module sync_read_port
  import ipc_sync_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  side_state_t       own,
  input  logic [LANE_W-1:0] peer_tx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word                     = '0;
    word[EN_BIT]             = own.en;
    word[TX_LO +: LANE_W]    = own.tx;
    word[RX_LO +: LANE_W]    = peer_tx;
  end

  always_ff @(posedge clk) begin
    if (rst)                              rdata <= '0;
    else if (addr == ADDR_W'(REG_ADDR))   rdata <= word;
    else                                  rdata <= '0;
  end
endmodule

// File: rtl/ipc_sync_doorbell.sv
module ipc_sync_doorbell
  import ipc_sync_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s0_addr,
  input  logic              s0_wr,
  input  logic [31:0]       s0_wdata,
  input  logic [3:0]        s0_be,
  output logic [31:0]       s0_rdata,
  output logic              s0_irq,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic              s1_wr,
  input  logic [31:0]       s1_wdata,
  input  logic [3:0]        s1_be,
  output logic [31:0]       s1_rdata,
  output logic              s1_irq
);
  logic [ADDR_W-1:0] p_addr  [SIDES];
  logic              p_wr    [SIDES];
  logic [WORD_W-1:0] p_wdata [SIDES];
  logic [LANES-1:0]  p_be    [SIDES];
  logic [WORD_W-1:0] p_rdata [SIDES];
  side_state_t       st      [SIDES];
  logic [SIDES-1:0]  ring;
  logic [SIDES-1:0]  irq_vec;
  logic [SIDES-1:0]  en_vec;

  assign p_addr[0]  = s0_addr;
  assign p_addr[1]  = s1_addr;
  assign p_wr[0]    = s0_wr;
  assign p_wr[1]    = s1_wr;
  assign p_wdata[0] = s0_wdata;
  assign p_wdata[1] = s1_wdata;
  assign p_be[0]    = s0_be;
  assign p_be[1]    = s1_be;
  assign s0_rdata   = p_rdata[0];
  assign s1_rdata   = p_rdata[1];
  assign s0_irq     = irq_vec[0];
  assign s1_irq     = irq_vec[1];

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    localparam int PEER = 1 - g;

    assign en_vec[g] = st[g].en;

    sync_side_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SIDE(g)) u_regs (
      .clk(clk), .rst(rst), .addr(p_addr[g]), .wr(p_wr[g]),
      .wdata(p_wdata[g]), .be(p_be[g]), .state(st[g]), .ring_peer(ring[g])
    );

    sync_irq_gate u_gate (
      .clk(clk), .rst(rst), .ring(ring[PEER]), .en(st[g].en), .irq(irq_vec[g])
    );

    sync_read_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
      .clk(clk), .rst(rst), .addr(p_addr[g]), .own(st[g]),
      .peer_tx(st[PEER].tx), .rdata(p_rdata[g])
    );
  end
endmodule

// File: rtl/ipc_sync_checker.sv
module ipc_sync_checker #(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] s0_addr,
  input logic              s0_wr,
  input logic [31:0]       s0_wdata,
  input logic [3:0]        s0_be,
  input logic [31:0]       s0_rdata,
  input logic              s0_irq,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s1_wr,
  input logic [31:0]       s1_wdata,
  input logic [3:0]        s1_be,
  input logic [31:0]       s1_rdata,
  input logic              s1_irq,
  input logic [1:0]        en_vec
);
  logic hit0, hit1;
  logic unused_chk;
  assign hit0 = s0_wr && (s0_addr == ADDR_W'(REG_ADDR));
  assign hit1 = s1_wr && (s1_addr == ADDR_W'(REG_ADDR));
  assign unused_chk = ^{s0_wdata[28:0], s0_be[2:0], s1_wdata[28:0], s1_be[2:0],
                        s0_wdata[30], s1_wdata[29]};

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (s0_rdata == 32'd0 && s1_rdata == 32'd0 && !s0_irq && !s1_irq));

  p_en0_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(hit0 && s0_be[3]) |=> (en_vec[0] == $past(en_vec[0])));

  p_en1_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(hit1 && s1_be[3]) |=> (en_vec[1] == $past(en_vec[1])));

  p_irq1_cause_r5: assert property (@(posedge clk) disable iff (rst)
    s1_irq |-> $past(hit0 && s0_be[3] && s0_wdata[29]));

  p_irq0_cause_r5: assert property (@(posedge clk) disable iff (rst)
    s0_irq |-> $past(hit1 && s1_be[3] && s1_wdata[30]));

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (s0_irq |-> $past(en_vec[0])) and (s1_irq |-> $past(en_vec[1])));

  p_zero_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (s0_rdata[30:16] == 15'd0) && (s1_rdata[30:16] == 15'd0));
endmodule

bind ipc_sync_doorbell ipc_sync_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst),
  .s0_addr(s0_addr), .s0_wr(s0_wr), .s0_wdata(s0_wdata), .s0_be(s0_be),
  .s0_rdata(s0_rdata), .s0_irq(s0_irq),
  .s1_addr(s1_addr), .s1_wr(s1_wr), .s1_wdata(s1_wdata), .s1_be(s1_be),
  .s1_rdata(s1_rdata), .s1_irq(s1_irq),
  .en_vec(en_vec)
);

// File: tb/tb_ipc_sync_doorbell.sv
module tb_ipc_sync_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int NV         = 10;

  typedef struct packed {
    logic        side;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] r0;
    logic [31:0] r1;
    logic        i0;
    logic        i1;
  } vec_t;

  // Expected register states tracked by hand from the requirements.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_A500, 4'b0010, 32'h0000_A500, 32'h0000_00A5, 1'b0, 1'b0}, // R2 R3
    '{1'b1, 32'h8000_3C00, 4'b1010, 32'h0000_A53C, 32'h8000_3CA5, 1'b0, 1'b0}, // R4
    '{1'b0, 32'h2000_0000, 4'b1000, 32'h0000_A53C, 32'h8000_3CA5, 1'b0, 1'b1}, // R5
    '{1'b1, 32'hC000_0000, 4'b1000, 32'h0000_A53C, 32'h8000_3CA5, 1'b0, 1'b0}, // R6
    '{1'b0, 32'h8000_0000, 4'b1000, 32'h8000_A53C, 32'h8000_3CA5, 1'b0, 1'b0}, // R6 no late ring
    '{1'b1, 32'hC000_0000, 4'b1000, 32'h8000_A53C, 32'h8000_3CA5, 1'b1, 1'b0}, // R5
    '{1'b0, 32'hC000_00FF, 4'b1001, 32'h8000_A53C, 32'h8000_3CA5, 1'b0, 1'b0}, // R7 R3
    '{1'b0, 32'h2000_7700, 4'b0111, 32'h8000_773C, 32'h8000_3C77, 1'b0, 1'b0}, // R8
    '{1'b0, 32'hFFFF_FFFF, 4'b1111, 32'h8000_FF3C, 32'h8000_3CFF, 1'b0, 1'b1}, // R7 R5
    '{1'b1, 32'h0000_1200, 4'b0010, 32'h8000_FF12, 32'h8000_12FF, 1'b0, 1'b0}  // R2
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] s0_addr = '0, s1_addr = '0;
  logic              s0_wr = 1'b0, s1_wr = 1'b0;
  logic [31:0]       s0_wdata = '0, s1_wdata = '0;
  logic [3:0]        s0_be = '0, s1_be = '0;
  logic [31:0]       s0_rdata, s1_rdata;
  logic              s0_irq, s1_irq;
  int                total = 0;
  int                bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_sync_doorbell #(.ADDR_W(ADDR_W), .REG_ADDR(0)) dut (
    .clk(clk), .rst(rst),
    .s0_addr(s0_addr), .s0_wr(s0_wr), .s0_wdata(s0_wdata), .s0_be(s0_be),
    .s0_rdata(s0_rdata), .s0_irq(s0_irq),
    .s1_addr(s1_addr), .s1_wr(s1_wr), .s1_wdata(s1_wdata), .s1_be(s1_be),
    .s1_rdata(s1_rdata), .s1_irq(s1_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic side, input logic [31:0] wd, input logic [3:0] be);
    if (side == 1'b0) begin s0_wr = 1'b1; s0_wdata = wd; s0_be = be; end
    else              begin s1_wr = 1'b1; s1_wdata = wd; s1_be = be; end
  endtask

  task automatic release_bus();
    s0_wr = 1'b0; s1_wr = 1'b0; s0_be = '0; s1_be = '0; s0_wdata = '0; s1_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 s0_rdata after reset", s0_rdata, 32'h0);
    chk("R1 s1_rdata after reset", s1_rdata, 32'h0);
    chk("R1 irqs after reset", {30'd0, s1_irq, s0_irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].side, VECS[k].wd, VECS[k].be);
      @(negedge clk);
      release_bus();
      chk($sformatf("R5 R6 irq0 vec %0d", k), {31'd0, s0_irq}, {31'd0, VECS[k].i0});
      chk($sformatf("R5 R6 irq1 vec %0d", k), {31'd0, s1_irq}, {31'd0, VECS[k].i1});
      @(negedge clk);
      chk($sformatf("R10 irq width vec %0d", k), {30'd0, s1_irq, s0_irq}, 32'h0);
      chk($sformatf("R10 s0_rdata vec %0d", k), s0_rdata, VECS[k].r0);
      chk($sformatf("R10 s1_rdata vec %0d", k), s1_rdata, VECS[k].r1);
    end

    // R9: wrong address ignored for write and read
    s0_addr = 4'd1;
    drive(1'b0, 32'hA000_5500, 4'b1111);
    @(negedge clk);
    release_bus();
    chk("R9 no ring from wrong address", {31'd0, s1_irq}, 32'h0);
    @(negedge clk);
    chk("R9 read at wrong address", s0_rdata, 32'h0);
    s0_addr = 4'd0;
    @(negedge clk);
    chk("R9 s0 state unchanged", s0_rdata, 32'h8000_FF12);
    chk("R9 s1 view unchanged", s1_rdata, 32'h8000_12FF);

    // R5: both sides ring each other in one cycle
    drive(1'b0, 32'hA000_0000, 4'b1000);
    drive(1'b1, 32'hC000_0000, 4'b1000);
    @(negedge clk);
    release_bus();
    chk("R5 simultaneous rings", {30'd0, s1_irq, s0_irq}, 32'h3);
    @(negedge clk);
    chk("R5 simultaneous rings end", {30'd0, s1_irq, s0_irq}, 32'h0);

    // R1: reset in mid-run clears state and enables
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 s0_rdata after mid reset", s0_rdata, 32'h0);
    chk("R1 s1_rdata after mid reset", s1_rdata, 32'h0);
    drive(1'b1, 32'h4000_0000, 4'b1000);
    @(negedge clk);
    release_bus();
    chk("R1 ring after reset dropped", {31'd0, s0_irq}, 32'h0);
    @(negedge clk);
    chk("R1 s0 still clear", s0_rdata, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule